// File: doc/BRIEF.md
# Paired-Register Quadword Compare-and-Swap Unit

This unit executes one 128-bit atomic compare-and-swap instruction, whose operands come from pairs of 64-bit general registers. Each run starts from a one-cycle `start` pulse carrying a 32-bit instruction word. The unit decodes the word and rejects illegal forms. It then reads its operands one register per cycle through a single register-file read port: the even/odd compare pair, the even/odd new-value pair, and the base register. The stack pointer replaces the base register when the base field is 31.

The memory operation is a locked read beat followed at once by a locked write beat on a 128-bit request/acknowledge port. The write carries the new value only when the memory word equals the compare value and the external permission verdict passes. In every other case the unit writes back the word it read, under the same lock. The word that was read then goes back into the compare pair in two register writes. The order of the two halves follows the endianness input. The unit raises `done` for one cycle. With that pulse it reports the condition flags, or an undefined-instruction or alignment-fault indication.

Top module: `qcas_unit`

## Requirements
- R1: `undef` is high with `done`, and no memory request or register write occurs, when `feat_en` is low or any fixed opcode field differs. The fixed fields are instr[31:24]=8'h49, instr[21]=1 and instr[15:10]=6'b000011.
- R2: `undef` is raised in the same way when the compare field instr[20:16] or the new-value field instr[4:0] is odd.
- R3: The compare value is {reg[s], reg[s+1]} when `big_endian` is 1 and {reg[s+1], reg[s]} when it is 0. The new value is built the same way from reg[t] and reg[t+1].
- R4: The address is reg[instr[9:5]] when that field is not 31, and `sp_value` when it is 31. `mem_tagchk` is high on the requests only when the field is not 31.
- R5: When the base field is 31 and `sp_value[3:0]` is not zero, `align_fault` is high with `done`. No memory request or register write occurs, and `flags` keep their value.
- R6: Each legal operation makes exactly one read beat followed by exactly one write beat to the same address. `mem_lock` stays high from the read beat until the write beat is acknowledged. A request holds its address and direction until it is acknowledged.
- R7: The write beat carries the new value when the read word equals the compare value and `perm_ok` is 1. `perm_ok` is sampled when the read beat is acknowledged. Otherwise the write beat carries the read word.
- R8: After the write, the read word is written to the compare pair. With `big_endian`=1, bits [127:64] go to reg[s] and bits [63:0] go to reg[s+1]. With `big_endian`=0 the halves are swapped.
- R9: `flags` is {N,Z,C,V} and resets to 0000. A completed operation sets it to {0, stored, 0, 0}, where stored means the new value was written. Undefined and faulting operations leave `flags` unchanged. `done` is a one-cycle pulse.
- R10: `mem_acq` equals instr[23] on the read beat and is 0 on the write beat. `mem_rel` equals instr[22] on the write beat and is 0 on the read beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins an operation; ignored while busy |
| instr | input | 32 | Instruction word, sampled with `start` |
| big_endian | input | 1 | Register-pair ordering, sampled with `start` |
| feat_en | input | 1 | Feature enable; low makes the instruction undefined |
| sp_value | input | 64 | Stack-pointer value |
| perm_ok | input | 1 | External permission-check verdict |
| rf_raddr | output | 5 | Register-file read address |
| rf_rdata | input | 64 | Register-file read data, valid in the same cycle |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | 5 | Register-file write address |
| rf_wdata | output | 64 | Register-file write data |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Request is a write beat |
| mem_lock | output | 1 | Locked-access marker |
| mem_acq | output | 1 | Acquire tag |
| mem_rel | output | 1 | Release tag |
| mem_tagchk | output | 1 | Tag-check request |
| mem_addr | output | 64 | Memory address |
| mem_wdata | output | 128 | Write-beat data |
| mem_ack | input | 1 | One-cycle acknowledge of the current beat |
| mem_rdata | input | 128 | Read data, valid with `mem_ack` on a read beat |
| done | output | 1 | Operation-complete pulse |
| undef | output | 1 | Undefined-instruction indication, valid with `done` |
| align_fault | output | 1 | Stack-pointer alignment fault, valid with `done` |
| flags | output | 4 | Condition flags {N,Z,C,V} |

## Verification
The assertions assume the memory side acknowledges only a pending request, gives at most one acknowledge per beat, and eventually responds. The bench's responder acknowledges a held request after a random delay and then drops its acknowledge. The assertions also assume `perm_ok` and `sp_value` are steady for the whole operation. The stimulus changes these inputs, and the register and memory contents, only between operations, while the unit is idle.

// File: rtl/qcas_pkg.sv
// Shared constants and types for the quadword compare-and-swap unit.
// Assumes 5-bit register indices and a 32-bit instruction word.
package qcas_pkg;
    localparam int REG_AW = 5;
    localparam logic [REG_AW-1:0] SP_REG = 5'd31;
    localparam logic [7:0] OPC_HI  = 8'h49;
    localparam logic [5:0] OPC_MID = 6'b000011;

    typedef struct packed {
        logic [REG_AW-1:0] rs;
        logic [REG_AW-1:0] rn;
        logic [REG_AW-1:0] rt;
        logic              acq;
        logic              rel;
    } qcas_dec_t;

    typedef enum logic [3:0] {
        ST_IDLE, ST_DEC, ST_RS0, ST_RS1, ST_RT0, ST_RT1, ST_RN,
        ST_MRD, ST_MWR, ST_WB0, ST_WB1, ST_DONE
    } qcas_state_t;
endpackage

// File: rtl/qcas_decode.sv
// Instruction decoder: splits the fields out of the word and flags illegal forms.
// Assumes the word is held steady while it is decoded (purely combinational).
module qcas_decode
    import qcas_pkg::*;
(
    input  logic [31:0] instr,
    input  logic        feat_en,
    output qcas_dec_t   dec,
    output logic        illegal
);
    logic fixed_ok;

    // Field extraction and legality check.
    always_comb begin
        dec.rs   = instr[20:16];
        dec.rn   = instr[9:5];
        dec.rt   = instr[4:0];
        dec.acq  = instr[23];
        dec.rel  = instr[22];
        fixed_ok = (instr[31:24] == OPC_HI) && instr[21] && (instr[15:10] == OPC_MID);
        illegal  = !feat_en || !fixed_ok || instr[16] || instr[0];
    end
endmodule

// File: rtl/qcas_pack.sv
// Joins an even/odd register pair into one quadword in the selected byte order.
// Assumes even_val is reg[k] and odd_val is reg[k+1].
module qcas_pack #(
    parameter int XLEN = 64
) (
    input  logic              be,
    input  logic [XLEN-1:0]   even_val,
    input  logic [XLEN-1:0]   odd_val,
    output logic [2*XLEN-1:0] quad
);
    // Order the halves by endianness.
    always_comb quad = be ? {even_val, odd_val} : {odd_val, even_val};
endmodule

// File: rtl/qcas_unpack.sv
// Splits a quadword back into even/odd register values in the selected byte order.
// Assumes the inverse ordering of qcas_pack.
module qcas_unpack #(
    parameter int XLEN = 64
) (
    input  logic              be,
    input  logic [2*XLEN-1:0] quad,
    output logic [XLEN-1:0]   even_val,
    output logic [XLEN-1:0]   odd_val
);
    // Select the half that goes to each register.
    always_comb begin
        even_val = be ? quad[2*XLEN-1:XLEN] : quad[XLEN-1:0];
        odd_val  = be ? quad[XLEN-1:0]      : quad[2*XLEN-1:XLEN];
    end
endmodule

// File: rtl/qcas_unit.sv
// Sequencer for the paired-register quadword compare-and-swap.
// It decodes the word, reads five operands one per cycle, and checks
// stack-pointer alignment. It then performs a locked read beat and a locked
// write beat and returns the read word to the compare pair.
// Assumes: the register read port answers in the same cycle; the memory side
// acknowledges each held request exactly once; perm_ok and sp_value are
// steady during an operation.
module qcas_unit
    import qcas_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [31:0]       instr,
    input  logic              big_endian,
    input  logic              feat_en,
    input  logic [XLEN-1:0]   sp_value,
    input  logic              perm_ok,
    output logic [4:0]        rf_raddr,
    input  logic [XLEN-1:0]   rf_rdata,
    output logic              rf_we,
    output logic [4:0]        rf_waddr,
    output logic [XLEN-1:0]   rf_wdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_lock,
    output logic              mem_acq,
    output logic              mem_rel,
    output logic              mem_tagchk,
    output logic [XLEN-1:0]   mem_addr,
    output logic [2*XLEN-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [2*XLEN-1:0] mem_rdata,
    output logic              done,
    output logic              undef,
    output logic              align_fault,
    output logic [3:0]        flags
);
    localparam int QLEN    = 2 * XLEN;
    localparam int ALIGN_W = $clog2(QLEN / 8);

    qcas_state_t       state;
    logic [31:0]       instr_q;
    logic              be_q;
    qcas_dec_t         dec;
    logic              illegal;
    logic [XLEN-1:0]   s0_q, s1_q, t0_q, t1_q, base_q;
    logic [QLEN-1:0]   rdata_q, wdata_q;
    logic              undef_q, fault_q;
    logic [3:0]        flags_q;
    logic [QLEN-1:0]   cmp_w, new_w;
    logic [XLEN-1:0]   back_even, back_odd;
    logic              stored_w, sp_base, sp_misalign;

    qcas_decode u_dec (
        .instr   (instr_q),
        .feat_en (feat_en),
        .dec     (dec),
        .illegal (illegal)
    );

    qcas_pack #(.XLEN(XLEN)) u_pack_cmp (
        .be (be_q), .even_val (s0_q), .odd_val (s1_q), .quad (cmp_w)
    );

    qcas_pack #(.XLEN(XLEN)) u_pack_new (
        .be (be_q), .even_val (t0_q), .odd_val (t1_q), .quad (new_w)
    );

    qcas_unpack #(.XLEN(XLEN)) u_unpack (
        .be (be_q), .quad (rdata_q), .even_val (back_even), .odd_val (back_odd)
    );

    // Store decision and base-source flags.
    always_comb begin
        stored_w    = (mem_rdata == cmp_w) && perm_ok;
        sp_base     = (dec.rn == SP_REG);
        sp_misalign = sp_base && (sp_value[ALIGN_W-1:0] != '0);
    end

    // Main sequencer and operand capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            instr_q <= '0;
            be_q    <= 1'b0;
            s0_q    <= '0;
            s1_q    <= '0;
            t0_q    <= '0;
            t1_q    <= '0;
            base_q  <= '0;
            rdata_q <= '0;
            wdata_q <= '0;
            undef_q <= 1'b0;
            fault_q <= 1'b0;
            flags_q <= 4'b0000;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    instr_q <= instr;
                    be_q    <= big_endian;
                    undef_q <= 1'b0;
                    fault_q <= 1'b0;
                    state   <= ST_DEC;
                end
                ST_DEC: begin
                    if (illegal) begin
                        undef_q <= 1'b1;
                        state   <= ST_DONE;
                    end else begin
                        state <= ST_RS0;
                    end
                end
                ST_RS0: begin s0_q <= rf_rdata; state <= ST_RS1; end
                ST_RS1: begin s1_q <= rf_rdata; state <= ST_RT0; end
                ST_RT0: begin t0_q <= rf_rdata; state <= ST_RT1; end
                ST_RT1: begin t1_q <= rf_rdata; state <= ST_RN;  end
                ST_RN: begin
                    base_q <= sp_base ? sp_value : rf_rdata;
                    if (sp_misalign) begin
                        fault_q <= 1'b1;
                        state   <= ST_DONE;
                    end else begin
                        state <= ST_MRD;
                    end
                end
                ST_MRD: if (mem_ack) begin
                    rdata_q <= mem_rdata;
                    wdata_q <= stored_w ? new_w : mem_rdata;
                    flags_q <= {1'b0, stored_w, 2'b00};
                    state   <= ST_MWR;
                end
                ST_MWR: if (mem_ack) state <= ST_WB0;
                ST_WB0: state <= ST_WB1;
                ST_WB1: state <= ST_DONE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Register-file read address per operand-fetch state.
    always_comb begin
        case (state)
            ST_RS0:  rf_raddr = dec.rs;
            ST_RS1:  rf_raddr = dec.rs | 5'd1;
            ST_RT0:  rf_raddr = dec.rt;
            ST_RT1:  rf_raddr = dec.rt | 5'd1;
            ST_RN:   rf_raddr = dec.rn;
            default: rf_raddr = '0;
        endcase
    end

    // Register-file write-back of the read quadword.
    always_comb begin
        rf_we    = (state == ST_WB0) || (state == ST_WB1);
        rf_waddr = (state == ST_WB1) ? (dec.rs | 5'd1) : dec.rs;
        rf_wdata = (state == ST_WB1) ? back_odd : back_even;
    end

    // Memory port driven from the beat states.
    always_comb begin
        mem_req    = (state == ST_MRD) || (state == ST_MWR);
        mem_we     = (state == ST_MWR);
        mem_lock   = mem_req;
        mem_acq    = (state == ST_MRD) && dec.acq;
        mem_rel    = (state == ST_MWR) && dec.rel;
        mem_tagchk = mem_req && !sp_base;
        mem_addr   = base_q;
        mem_wdata  = wdata_q;
    end

    // Completion outputs.
    always_comb begin
        done        = (state == ST_DONE);
        undef       = done && undef_q;
        align_fault = done && fault_q;
        flags       = flags_q;
    end

    // R6: an acknowledged read beat is followed at once by a locked write beat.
    p_lock_into_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && mem_ack) |=> (mem_req && mem_we && mem_lock));

    // R6: a pending request holds its address and direction.
    p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R5: a stack-pointer address reaching memory is quadword aligned.
    p_sp_align_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_tagchk) |-> (mem_addr[ALIGN_W-1:0] == '0));

    // R7: write data is either the packed new value or the word that was read.
    p_wdata_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> ((mem_wdata == new_w) || (mem_wdata == rdata_q)));

    // R10: acquire never tags a write, release never tags a read.
    p_tag_dir_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> ((mem_we && !mem_acq) || (!mem_we && !mem_rel)));

    // R9: completion is a single-cycle pulse.
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R1: no memory or register activity on an undefined instruction.
    p_undef_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DEC && illegal) |=> (!mem_req && !rf_we));
endmodule

// File: tb/tb_qcas_unit.sv
`timescale 1ns/1ps
module tb_qcas_unit;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [31:0]  instr = '0;
    logic         big_endian = 1'b0;
    logic         feat_en = 1'b1;
    logic [63:0]  sp_value = '0;
    logic         perm_ok = 1'b1;
    logic [4:0]   rf_raddr;
    logic [63:0]  rf_rdata;
    logic         rf_we;
    logic [4:0]   rf_waddr;
    logic [63:0]  rf_wdata;
    logic         mem_req, mem_we, mem_lock, mem_acq, mem_rel, mem_tagchk;
    logic [63:0]  mem_addr;
    logic [127:0] mem_wdata;
    logic         mem_ack = 1'b0;
    logic [127:0] mem_rdata = '0;
    logic         done, undef, align_fault;
    logic [3:0]   flags;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    logic [63:0]  rf [32];
    logic [127:0] mem_word;
    int           rd_cnt, wr_cnt, rfw_cnt, lock_err;
    logic         in_atomic;
    logic         rd_acq, rd_rel, rd_tag, wr_acq, wr_rel;
    logic [63:0]  rd_addr, wr_addr;
    logic [3:0]   exp_flags = 4'b0000;

    always #10 clk = ~clk;

    qcas_unit dut (
        .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
        .big_endian(big_endian), .feat_en(feat_en), .sp_value(sp_value),
        .perm_ok(perm_ok), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
        .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_lock(mem_lock),
        .mem_acq(mem_acq), .mem_rel(mem_rel), .mem_tagchk(mem_tagchk),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .done(done), .undef(undef),
        .align_fault(align_fault), .flags(flags)
    );

    assign rf_rdata = rf[rf_raddr];

    // Register-file writes, memory responder and beat monitor.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (rf_we) begin
            rf[rf_waddr] <= rf_wdata;
            rfw_cnt <= rfw_cnt + 1;
        end
        if (in_atomic && !mem_lock) lock_err <= lock_err + 1;
        mem_ack <= 1'b0;
        if (mem_req && mem_ack) begin
            if (mem_we) begin
                mem_word <= mem_wdata;
                wr_cnt <= wr_cnt + 1;
                wr_acq <= mem_acq;
                wr_rel <= mem_rel;
                wr_addr <= mem_addr;
                in_atomic <= 1'b0;
            end else begin
                rd_cnt <= rd_cnt + 1;
                rd_acq <= mem_acq;
                rd_rel <= mem_rel;
                rd_tag <= mem_tagchk;
                rd_addr <= mem_addr;
                in_atomic <= 1'b1;
            end
        end else if (mem_req && ($urandom_range(0, 2) != 0)) begin
            mem_ack <= 1'b1;
            if (!mem_we) mem_rdata <= mem_word;
        end
    end

    task automatic chk(input string req, input string what, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic a, input logic r, input logic [4:0] s,
                                       input logic [4:0] n, input logic [4:0] t);
        return {1'b0, 1'b1, 6'b001001, a, r, 1'b1, s, 6'b000011, n, t};
    endfunction

    function automatic logic [127:0] pair(input logic be, input logic [63:0] ev, input logic [63:0] od);
        return be ? {ev, od} : {od, ev};
    endfunction

    // Runs one operation and checks all outcomes against the requirements.
    task automatic run_op(input logic [31:0] ins, input logic be, input logic perm, input logic fe);
        logic [4:0] s, n, t, s1, t1;
        logic xu, xf, stored;
        logic [127:0] cmp, nv, old, expw;
        logic [63:0] addr, pre_s, pre_s1;
        int waited;
        s = ins[20:16]; n = ins[9:5]; t = ins[4:0];
        s1 = s | 5'd1; t1 = t | 5'd1;
        xu = !fe || ins[31:24] != 8'h49 || !ins[21] || ins[15:10] != 6'b000011 || s[0] || t[0];
        xf = !xu && n == 5'd31 && sp_value[3:0] != 4'h0;
        cmp = pair(be, rf[s], rf[s1]);
        nv = pair(be, rf[t], rf[t1]);
        old = mem_word;
        addr = (n == 5'd31) ? sp_value : rf[n];
        stored = (old == cmp) && perm;
        expw = stored ? nv : old;
        pre_s = rf[s]; pre_s1 = rf[s1];
        rd_cnt = 0; wr_cnt = 0; rfw_cnt = 0; lock_err = 0;
        @(negedge clk);
        instr = ins; big_endian = be; perm_ok = perm; feat_en = fe; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        waited = 0;
        while (!done && waited < 300) begin
            @(negedge clk);
            waited++;
        end
        chk("R6", "done seen", done, 1'b1);
        chk(xu ? "R2" : "R1", "undef", undef, xu);
        chk("R5", "align_fault", align_fault, xf);
        if (xu || xf) begin
            chk(xu ? "R1" : "R5", "read beats", rd_cnt, 0);
            chk(xu ? "R1" : "R5", "write beats", wr_cnt, 0);
            chk(xu ? "R1" : "R5", "reg writes", rfw_cnt, 0);
            chk("R9", "flags kept", flags, exp_flags);
        end else begin
            exp_flags = {1'b0, stored, 2'b00};
            chk("R6", "read beats", rd_cnt, 1);
            chk("R6", "write beats", wr_cnt, 1);
            chk("R6", "lock gaps", lock_err, 0);
            chk("R4", "read address", rd_addr, addr);
            chk("R6", "write address", wr_addr, addr);
            chk("R4", "tag check", rd_tag, n != 5'd31);
            chk("R10", "read acquire", rd_acq, ins[23]);
            chk("R10", "read release", rd_rel, 1'b0);
            chk("R10", "write release", wr_rel, ins[22]);
            chk("R10", "write acquire", wr_acq, 1'b0);
            chk(stored ? "R3" : "R7", "memory after", mem_word, expw);
            chk("R8", "reg s", rf[s], be ? old[127:64] : old[63:0]);
            chk("R8", "reg s+1", rf[s1], be ? old[63:0] : old[127:64]);
            chk("R9", "flags", flags, exp_flags);
        end
        if (xu) begin
            chk("R1", "reg s kept", rf[s], pre_s);
            chk("R1", "reg s+1 kept", rf[s1], pre_s1);
        end
        @(negedge clk);
        chk("R9", "done pulse", done, 1'b0);
    endtask

    task automatic fill_regs();
        for (int i = 0; i < 32; i++) rf[i] = {$urandom, $urandom};
    endtask

    // Watchdog.
    always @(posedge clk) begin
        if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [127:0] cmpv;
        void'($urandom(32'h5eed_1234));
        mem_word = '0;
        in_atomic = 1'b0;
        rd_cnt = 0; wr_cnt = 0; rfw_cnt = 0; lock_err = 0;
        fill_regs();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9", "reset flags", flags, 4'b0000);
        chk("R9", "reset done", done, 1'b0);
        chk("R6", "reset mem_req", mem_req, 1'b0);

        // Little-endian equal compare, permission passes: store, acquire only.
        mem_word = pair(1'b0, rf[4], rf[5]);
        run_op(mk(1, 0, 5'd4, 5'd7, 5'd10), 1'b0, 1'b1, 1'b1);
        // Big-endian equal compare, release only.
        mem_word = pair(1'b1, rf[2], rf[3]);
        run_op(mk(0, 1, 5'd2, 5'd9, 5'd12), 1'b1, 1'b1, 1'b1);
        // Wrong order: big-endian value, little-endian run, so compare fails.
        rf[6] = 64'h1111; rf[7] = 64'h2222;
        mem_word = pair(1'b1, rf[6], rf[7]);
        run_op(mk(1, 1, 5'd6, 5'd9, 5'd14), 1'b0, 1'b1, 1'b1);
        // Equal compare but permission fails.
        mem_word = pair(1'b0, rf[8], rf[9]);
        run_op(mk(0, 0, 5'd8, 5'd3, 5'd16), 1'b0, 1'b0, 1'b1);
        // Odd compare field, odd new-value field.
        run_op(mk(0, 0, 5'd5, 5'd3, 5'd16), 1'b0, 1'b1, 1'b1);
        run_op(mk(0, 0, 5'd4, 5'd3, 5'd17), 1'b0, 1'b1, 1'b1);
        // Feature disabled; corrupted fixed fields.
        run_op(mk(0, 0, 5'd4, 5'd3, 5'd16), 1'b0, 1'b1, 1'b0);
        run_op(mk(0, 0, 5'd4, 5'd3, 5'd16) ^ 32'h0000_0400, 1'b0, 1'b1, 1'b1);
        run_op(mk(0, 0, 5'd4, 5'd3, 5'd16) & ~32'h0020_0000, 1'b0, 1'b1, 1'b1);
        // Stack-pointer base aligned, then misaligned.
        sp_value = 64'h0000_0000_8000_1230;
        mem_word = pair(1'b1, rf[20], rf[21]);
        run_op(mk(1, 1, 5'd20, 5'd31, 5'd22), 1'b1, 1'b1, 1'b1);
        sp_value = 64'h0000_0000_8000_1238;
        run_op(mk(1, 1, 5'd20, 5'd31, 5'd22), 1'b1, 1'b1, 1'b1);

        // Constrained random mix.
        for (int k = 0; k < 60; k++) begin
            logic [4:0] rs, rn, rt;
            logic be;
            fill_regs();
            rs = 5'($urandom_range(0, 15) * 2);
            rt = 5'($urandom_range(0, 15) * 2);
            rn = ($urandom_range(0, 3) == 0) ? 5'd31 : 5'($urandom_range(0, 30));
            if ($urandom_range(0, 9) == 0) rs[0] = 1'b1;
            be = 1'($urandom_range(0, 1));
            sp_value = {$urandom, $urandom} & ~64'hF;
            if ($urandom_range(0, 7) == 0) sp_value[2] = 1'b1;
            cmpv = pair(be, rf[rs | 5'd1 & ~5'd1], rf[rs | 5'd1]);
            mem_word = ($urandom_range(0, 1) != 0) ? cmpv : {$urandom, $urandom, $urandom, $urandom};
            run_op(mk(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), rs, rn, rt),
                   be, ($urandom_range(0, 3) != 0), ($urandom_range(0, 15) != 0));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule